// File: doc/BRIEF.md
# External Sync Arm and Trigger Controller

This block lines up the sample channels of one converter interface, and of several interface instances, on a shared trigger event. Software arms it, disarms it and issues manual sync requests through single-cycle write strobes from a register decoder. The trigger itself arrives on an asynchronous external sync line. Once the block is armed, the first rising edge seen on that line produces one clock-wide channel-synchronization pulse. That pulse is consumed by the channel alignment logic downstream.

The manual request comes out as a one-cycle pulse. That pulse can be wired back into the external sync line inside the fabric, so one software write can trigger every instance that shares the line. A status bit reads high while a trigger is pending. It stays high after a trigger has completed, until the next reset.

The parameter `EXT_SYNC_EN` selects whether the logic is built at all. With the parameter at 0, every output is tied low and every strobe is ignored.

Top module: `ext_sync_trigger`

## Requirements
- R1: After reset, the block is disarmed and `sync_pulse`, `manual_sync_out` and `sync_status` are all 0.
- R2: When the block is armed and `ext_sync_in` rises, `sync_pulse` goes high for one cycle. This happens on the third rising clock edge after the input change: two synchronizer flops, then one output register.
- R3: Only a 0-to-1 transition of the synchronized input triggers. A level held high gives no further pulses, and a rise while disarmed gives no pulse.
- R4: Firing clears the armed state, so each arm write yields at most one pulse. A later rise gives no pulse until the block is armed again.
- R5: A disarm strobe cancels a pending arm. If no trigger has completed yet, `sync_status` returns to 0 on the next edge.
- R6: When arm and disarm strobes arrive in the same cycle, disarm wins and the block ends up disarmed.
- R7: `sync_status` is 1 from the edge after an arm strobe while a trigger is pending. It stays 1 from the firing edge onward until reset, whatever strobes follow.
- R8: A manual request strobe produces a one-cycle `manual_sync_out` pulse on the next edge. When that pulse is looped back to `ext_sync_in` while the block is armed, it fires `sync_pulse` three edges later.
- R9: With `EXT_SYNC_EN` = 0, all three outputs stay 0 for any strobes and any external input.
- R10: `sync_pulse` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_wr | input | 1 | Single-cycle strobe that arms the trigger |
| disarm_wr | input | 1 | Single-cycle strobe that cancels a pending arm |
| manual_req_wr | input | 1 | Single-cycle strobe that requests a manual sync event |
| ext_sync_in | input | 1 | Asynchronous external sync line |
| sync_pulse | output | 1 | One-cycle channel-synchronization pulse |
| manual_sync_out | output | 1 | One-cycle manual sync event, for loopback in the fabric |
| sync_status | output | 1 | High while waiting for a trigger and after a completed trigger |

## Verification
The assertions check the following on every cycle:
- the pulse is never wider than one cycle;
- no pulse appears without a synchronized rising edge;
- a disarm strobe always leaves the block disarmed;
- a firing leaves it disarmed unless it is re-armed in the same cycle;
- completion status never drops.

Only the bench's scenarios can show the end-to-end behaviour:
- the exact three-edge latency from the raw input to the pulse;
- the absence of pulses on a held level;
- the cancellation of status by disarm before any completion;
- the manual request looping back into a trigger;
- the silence of a disabled build.

// File: rtl/ext_sync_pkg.sv
package ext_sync_pkg;

    typedef struct packed {
        logic armed;
        logic done;
        logic pulse;
    } trig_state_t;

    localparam trig_state_t TRIG_RESET = '{armed: 1'b0, done: 1'b0, pulse: 1'b0};

endpackage

// File: rtl/ext_sync_edge.sv
module ext_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], async_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];

endmodule

// File: rtl/ext_sync_fsm.sv
module ext_sync_fsm
    import ext_sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_wr,
    input  logic disarm_wr,
    input  logic trig_rise,
    output logic sync_pulse,
    output logic sync_status
);
    trig_state_t st_d, st_q;
    logic        fire;

    always_comb begin
        st_d  = st_q;
        fire  = st_q.armed & trig_rise;
        st_d.pulse = fire;
        if (fire)      st_d.done  = 1'b1;
        if (fire)      st_d.armed = 1'b0;
        if (arm_wr)    st_d.armed = 1'b1;
        if (disarm_wr) st_d.armed = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TRIG_RESET;
        else        st_q <= st_d;
    end

    assign sync_pulse  = st_q.pulse;
    assign sync_status = st_q.armed | st_q.done;

    a_r6_disarm_wins: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_wr |=> !st_q.armed);

    a_r4_fire_consumes_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && trig_rise && !arm_wr) |=> !st_q.armed);

    a_r3_edge_needed: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_rise |=> !sync_pulse);

    a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> !sync_pulse);

    a_r7_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> sync_status);

endmodule

// File: rtl/ext_sync_trigger.sv
module ext_sync_trigger #(
    parameter bit EXT_SYNC_EN = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_wr,
    input  logic disarm_wr,
    input  logic manual_req_wr,
    input  logic ext_sync_in,
    output logic sync_pulse,
    output logic manual_sync_out,
    output logic sync_status
);
    generate
        if (EXT_SYNC_EN) begin : g_on
            logic rise;
            logic man_d, man_q;

            ext_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
                .clk      (clk),
                .rst_n    (rst_n),
                .async_in (ext_sync_in),
                .rise     (rise)
            );

            ext_sync_fsm u_fsm (
                .clk         (clk),
                .rst_n       (rst_n),
                .arm_wr      (arm_wr),
                .disarm_wr   (disarm_wr),
                .trig_rise   (rise),
                .sync_pulse  (sync_pulse),
                .sync_status (sync_status)
            );

            always_comb begin
                man_d = manual_req_wr;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) man_q <= 1'b0;
                else        man_q <= man_d;
            end

            assign manual_sync_out = man_q;

            a_r8_manual_pulse: assert property (@(posedge clk) disable iff (!rst_n)
                manual_req_wr |=> manual_sync_out);
        end else begin : g_off
            logic unused_in;
            assign unused_in       = &{1'b0, arm_wr, disarm_wr, manual_req_wr, ext_sync_in, clk, rst_n};
            assign sync_pulse      = 1'b0;
            assign manual_sync_out = 1'b0;
            assign sync_status     = 1'b0;
        end
    endgenerate

endmodule

// File: tb/ext_sync_trigger_tb.sv
module ext_sync_trigger_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm_wr = 1'b0, disarm_wr = 1'b0, man_wr = 1'b0, ext_drv = 1'b0, loop_en = 1'b0;
    logic sync_pulse, manual_sync_out, sync_status;
    logic d_pulse, d_man, d_status;
    logic ext_in;
    int   cyc = 0;
    int   n_chk = 0, n_fail = 0;
    int   exp_sync[$];
    int   exp_man[$];
    bit   done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign ext_in = ext_drv | (loop_en & manual_sync_out);

    ext_sync_trigger u_dut (
        .clk(clk), .rst_n(rst_n), .arm_wr(arm_wr), .disarm_wr(disarm_wr),
        .manual_req_wr(man_wr), .ext_sync_in(ext_in),
        .sync_pulse(sync_pulse), .manual_sync_out(manual_sync_out), .sync_status(sync_status)
    );

    ext_sync_trigger #(.EXT_SYNC_EN(1'b0)) u_dis (
        .clk(clk), .rst_n(rst_n), .arm_wr(arm_wr), .disarm_wr(disarm_wr),
        .manual_req_wr(man_wr), .ext_sync_in(ext_drv),
        .sync_pulse(d_pulse), .manual_sync_out(d_man), .sync_status(d_status)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drivers: apply at a negedge and push the expected cycle.
    task automatic strobe(input int which);
        if (which == 0) arm_wr = 1'b1;
        if (which == 1) disarm_wr = 1'b1;
        if (which == 2) begin arm_wr = 1'b1; disarm_wr = 1'b1; end
        step(1);
        arm_wr = 1'b0; disarm_wr = 1'b0;
    endtask

    task automatic raise_ext(input bit expect_pulse);
        if (expect_pulse) exp_sync.push_back(cyc + 3);
        ext_drv = 1'b1;
    endtask

    task automatic manual(input bit expect_sync);
        exp_man.push_back(cyc + 1);
        if (expect_sync) exp_sync.push_back(cyc + 4);
        man_wr = 1'b1;
        step(1);
        man_wr = 1'b0;
    endtask

    // Monitor: compare produced pulses against the scoreboard queues.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sync_pulse) begin
                if (exp_sync.size() > 0 && exp_sync[0] == cyc) begin
                    void'(exp_sync.pop_front());
                    check(1'b1, "R2", 1, 1);
                end else check(1'b0, "R3/R4 unexpected sync_pulse", 1, 0);
            end else if (exp_sync.size() > 0 && exp_sync[0] <= cyc) begin
                void'(exp_sync.pop_front());
                check(1'b0, "R2 missing sync_pulse", 0, 1);
            end
            if (manual_sync_out) begin
                if (exp_man.size() > 0 && exp_man[0] == cyc) begin
                    void'(exp_man.pop_front());
                    check(1'b1, "R8", 1, 1);
                end else check(1'b0, "R8 unexpected manual_sync_out", 1, 0);
            end else if (exp_man.size() > 0 && exp_man[0] <= cyc) begin
                void'(exp_man.pop_front());
                check(1'b0, "R8 missing manual_sync_out", 0, 1);
            end
            if (d_pulse | d_man | d_status)
                check(1'b0, "R9 disabled build output", int'({d_pulse, d_man, d_status}), 0);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        step(3);
        // R1 reset state
        check(sync_pulse == 0 && manual_sync_out == 0 && sync_status == 0, "R1",
              int'({sync_pulse, manual_sync_out, sync_status}), 0);
        rst_n = 1'b1;
        step(2);
        check(sync_status == 0, "R1 status after reset", sync_status, 0);

        // R3 rise while disarmed: no pulse
        raise_ext(1'b0);
        step(6);
        ext_drv = 1'b0;
        step(4);

        // R5 disarm cancels before any completion
        strobe(0);
        check(sync_status == 1, "R7 status while armed", sync_status, 1);
        strobe(1);
        check(sync_status == 0, "R5 status after disarm", sync_status, 0);
        raise_ext(1'b0);
        step(6);
        ext_drv = 1'b0;
        step(4);

        // R6 simultaneous arm and disarm
        strobe(2);
        check(sync_status == 0, "R6 disarm wins", sync_status, 0);
        raise_ext(1'b0);
        step(6);
        ext_drv = 1'b0;
        step(4);

        // R2 armed trigger, R3 held level
        strobe(0);
        raise_ext(1'b1);
        step(12);
        check(sync_status == 1, "R7 status after completion", sync_status, 1);
        ext_drv = 1'b0;
        step(4);

        // R4 second rise without re-arm
        raise_ext(1'b0);
        step(6);
        ext_drv = 1'b0;
        step(4);
        check(sync_status == 1, "R7 status sticky", sync_status, 1);

        // R7 disarm after completion keeps status
        strobe(1);
        check(sync_status == 1, "R7 status after late disarm", sync_status, 1);

        // R2 again after re-arm, with a short pulse on the input
        strobe(0);
        raise_ext(1'b1);
        step(1);
        ext_drv = 1'b0;
        step(8);

        // R8 manual request without loopback
        manual(1'b0);
        step(8);

        // R8 manual request looped back while armed
        loop_en = 1'b1;
        strobe(0);
        manual(1'b1);
        step(8);
        loop_en = 1'b0;

        // R1 reset clears status
        rst_n = 1'b0;
        step(2);
        check(sync_status == 0 && sync_pulse == 0, "R1 status cleared by reset",
              int'({sync_status, sync_pulse}), 0);
        rst_n = 1'b1;
        step(2);

        // R9 explicit check of the disabled build
        check(d_pulse == 0 && d_man == 0 && d_status == 0, "R9",
              int'({d_pulse, d_man, d_status}), 0);
        check(exp_sync.size() == 0, "R2 pending sync", exp_sync.size(), 0);
        check(exp_man.size() == 0, "R8 pending manual", exp_man.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // R10: pulse width is covered by the monitor: each pulse cycle must match a distinct queue entry.
endmodule